// File: doc/BRIEF.md
# Two-Buffer Ethernet Receive Controller

This block takes received Ethernet frames from a byte stream and stores each one in one of two receive buffers, which it fills in turn. The first frame after reset goes to buffer A, the next to buffer B, and so on. A completed frame sets a done flag on its buffer. That flag can raise an interrupt. Software reads the frame out of buffer memory through a simple register port. It then clears the done flag, which frees the buffer for a new frame.

A frame may arrive while the buffer it is meant for still holds an unread frame. In that case the whole frame is thrown away and a drop counter goes up by one. The turn order does not move on after a drop, so frames keep landing in strict alternation once software frees the buffer. The block does not filter addresses, check the FCS or drive the PHY interface.

Register port map (byte addresses, 32-bit words):

| Address | Meaning |
|---|---|
| 0x07F8 | Global interrupt enable, bit 31 |
| 0x1000 | Start of buffer A memory |
| 0x1800 | Start of buffer B memory |
| 0x17FC | Buffer A status word |
| 0x1FFC | Buffer B status word |

In each status word, bit 0 is the done flag and bit 3 is the interrupt enable.

Top module: `dual_rx_buffer`

## Requirements
- R1: After reset, all of the following are 0: both done flags, both interrupt enables, the global enable, `irq` and `drop_count`. The first frame stored after reset goes to buffer A.
- R2: Frame byte k is stored in its buffer at word k/4, bits [8*(k%4)+7 : 8*(k%4)]. Word k/4 sits at byte address base + 4*(k/4), where base is 0x1000 for buffer A and 0x1800 for buffer B.
- R3: Frames that are stored go to A, then B, then A, and so on.
- R4: When the last byte of a stored frame is accepted, that buffer's status bit 0 (done) reads as 1 from the next cycle on.
- R5: Writing a status word with bit 0 = 0 clears that buffer's done flag. Writing bit 0 = 1 leaves the done flag unchanged.
- R6: Status bit 3 is a read/write interrupt enable. `irq` is 1 exactly when the global enable is set and some buffer has both done and its enable set.
- R7: Bit 31 at address 0x07F8 is the global interrupt enable. It can be read back, and when it is 0, `irq` is held at 0.
- R8: A frame whose target buffer is still done is discarded completely. No buffer word changes, `drop_count` increments by one, and the next frame targets the same buffer.
- R9: At most MAX_BYTES (1518) bytes of a frame are stored, and any bytes past that are not written. A longer frame still sets done and still advances the turn.
- R10: A read request returns its data on `host_rdata` in the cycle after `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Read request strobe |
| host_addr | input | 13 | Byte address for read or write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Receive interrupt |
| drop_count | output | 16 | Number of frames discarded |

## Verification
Frames of several lengths are sent through the block, and their stored words are compared lane by lane with the expected byte order:
- a frame of one byte;
- frames that end part-way through a word;
- a frame longer than the buffer.

Together these separate errors in lane placement from errors in word stepping. Three orderings check that a drop leaves the turn order in place:
- fill A, then fill B;
- fill both buffers, then send a frame that must be dropped;
- free both buffers and check which one the next frame lands in.

Each interrupt enable and the global enable is switched separately while a frame is done, which shows that each gate acts on `irq` by itself.

// File: rtl/drb_pkg.sv
package drb_pkg;

    localparam int HOST_AW    = 13;
    localparam int WIN_WORD_W = 9;

    localparam logic [HOST_AW-1:0] GIE_ADDR  = 13'h07F8;
    localparam logic [HOST_AW-1:0] RX_BASE   = 13'h1000;
    localparam logic [HOST_AW-1:0] WIN_SPAN  = 13'h0800;
    localparam logic [HOST_AW-1:0] STAT_OFS  = 13'h07FC;

    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_IE_BIT   = 3;
    localparam int GIE_BIT       = 31;

    typedef struct packed {
        logic                  en;
        logic                  bsel;
        logic [WIN_WORD_W-1:0] word;
        logic [1:0]            lane;
        logic [7:0]            data;
    } ram_wr_t;

    typedef enum logic {SRC_REG = 1'b0, SRC_RAM = 1'b1} rd_src_e;

    function automatic logic [HOST_AW-1:0] stat_addr(input logic bsel);
        return RX_BASE + (bsel ? WIN_SPAN : '0) + STAT_OFS;
    endfunction

    function automatic logic [31:0] stat_word(input logic done, input logic ie);
        logic [31:0] w;
        w = '0;
        w[STAT_DONE_BIT] = done;
        w[STAT_IE_BIT]   = ie;
        return w;
    endfunction

endpackage

// File: rtl/drb_frame_writer.sv
module drb_frame_writer
    import drb_pkg::*;
#(
    parameter int MAX_BYTES = 1518,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [1:0]        buf_done,
    output ram_wr_t           wr,
    output logic              done_set,
    output logic              done_buf,
    output logic [DROP_W-1:0] drop_count
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic             fill_q;
    logic             active_q;
    logic             discard_q;
    logic [CNT_W-1:0] idx_q;

    logic             sof;
    logic             tgt_busy;
    logic             keep;
    logic [CNT_W-1:0] idx;
    logic             room;

    always_comb begin
        sof      = in_valid && !active_q;
        tgt_busy = buf_done[fill_q];
        keep     = sof ? !tgt_busy : !discard_q;
        idx      = sof ? '0 : idx_q;
        room     = idx < CNT_W'(MAX_BYTES);

        wr.en    = in_valid && keep && room;
        wr.bsel  = fill_q;
        wr.word  = WIN_WORD_W'(idx >> 2);
        wr.lane  = idx[1:0];
        wr.data  = in_data;

        done_set = in_valid && in_last && keep;
        done_buf = fill_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q     <= 1'b0;
            active_q   <= 1'b0;
            discard_q  <= 1'b0;
            idx_q      <= '0;
            drop_count <= '0;
        end else if (in_valid) begin
            active_q <= !in_last;
            if (sof) begin
                discard_q <= tgt_busy;
            end
            if (sof && tgt_busy) begin
                drop_count <= drop_count + 1'b1;
            end
            if (in_last) begin
                idx_q <= '0;
                if (keep) begin
                    fill_q <= ~fill_q;
                end
            end else if (room) begin
                idx_q <= idx + 1'b1;
            end else begin
                idx_q <= idx;
            end
        end
    end

endmodule

// File: rtl/drb_buffer_ram.sv
module drb_buffer_ram
    import drb_pkg::*;
#(
    parameter int WORDS = 380
) (
    input  logic                  clk,
    input  ram_wr_t               wr,
    input  logic                  rd_en,
    input  logic                  rd_bsel,
    input  logic [WIN_WORD_W-1:0] rd_word,
    output logic [31:0]           rd_q
);
    localparam int DEPTH = 2 * WORDS;
    localparam int IDX_W = $clog2(DEPTH);

    function automatic logic [IDX_W-1:0] flat_idx(input logic bsel,
                                                  input logic [WIN_WORD_W-1:0] word);
        return IDX_W'(word) + (bsel ? IDX_W'(WORDS) : '0);
    endfunction

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = flat_idx(wr.bsel, wr.word);
    assign rd_idx = flat_idx(rd_bsel, rd_word);

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (wr.en && wr.lane == 2'(l)) begin
                mem[wr_idx] <= wr.data;
            end
            if (rd_en) begin
                q <= mem[rd_idx];
            end
        end

        assign rd_q[8*l +: 8] = q;
    end

endmodule

// File: rtl/drb_status_regs.sv
module drb_status_regs
    import drb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    input  logic               done_set,
    input  logic               done_buf,
    output logic [1:0]         done,
    output logic [1:0]         ie,
    output logic               gie,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gie <= 1'b0;
        end else if (host_wr && host_addr == GIE_ADDR) begin
            gie <= host_wdata[GIE_BIT];
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic hit;
        assign hit = host_wr && host_addr == stat_addr(1'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                done[b] <= 1'b0;
                ie[b]   <= 1'b0;
            end else begin
                if (hit) begin
                    ie[b] <= host_wdata[STAT_IE_BIT];
                    if (!host_wdata[STAT_DONE_BIT]) begin
                        done[b] <= 1'b0;
                    end
                end
                if (done_set && done_buf == 1'(b)) begin
                    done[b] <= 1'b1;
                end
            end
        end
    end

    assign irq = gie && |(done & ie);

endmodule

// File: rtl/dual_rx_buffer.sv
module dual_rx_buffer
    import drb_pkg::*;
#(
    parameter int MAX_BYTES = 1518,
    parameter int DROP_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               irq,
    output logic [DROP_W-1:0]  drop_count
);
    localparam int WORDS = (MAX_BYTES + 3) / 4;

    ram_wr_t     ram_wr;
    logic        done_set;
    logic        done_buf;
    logic [1:0]  done_q;
    logic [1:0]  ie_q;
    logic        gie_q;
    logic        ram_hit;
    logic [31:0] ram_q;
    logic [31:0] reg_val;
    logic [31:0] reg_q;
    rd_src_e     src_q;

    drb_frame_writer #(.MAX_BYTES(MAX_BYTES), .DROP_W(DROP_W)) writer_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_last    (rx_last),
        .buf_done   (done_q),
        .wr         (ram_wr),
        .done_set   (done_set),
        .done_buf   (done_buf),
        .drop_count (drop_count)
    );

    assign ram_hit = host_addr[12] && (host_addr[10:2] < WIN_WORD_W'(WORDS));

    drb_buffer_ram #(.WORDS(WORDS)) ram_i (
        .clk     (clk),
        .wr      (ram_wr),
        .rd_en   (host_rd && ram_hit),
        .rd_bsel (host_addr[11]),
        .rd_word (host_addr[10:2]),
        .rd_q    (ram_q)
    );

    drb_status_regs status_i (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .done_set   (done_set),
        .done_buf   (done_buf),
        .done       (done_q),
        .ie         (ie_q),
        .gie        (gie_q),
        .irq        (irq)
    );

    always_comb begin
        reg_val = '0;
        if (host_addr == GIE_ADDR) begin
            reg_val[GIE_BIT] = gie_q;
        end else if (host_addr == stat_addr(1'b0)) begin
            reg_val = stat_word(done_q[0], ie_q[0]);
        end else if (host_addr == stat_addr(1'b1)) begin
            reg_val = stat_word(done_q[1], ie_q[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_REG;
            reg_q <= '0;
        end else if (host_rd) begin
            src_q <= ram_hit ? SRC_RAM : SRC_REG;
            reg_q <= reg_val;
        end
    end

    assign host_rdata = (src_q == SRC_RAM) ? ram_q : reg_q;

endmodule

// File: rtl/drb_chk.sv
module drb_chk
    import drb_pkg::*;
#(
    parameter int WORDS  = 380,
    parameter int DROP_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               rx_valid,
    input logic               rx_last,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [31:0]        host_wdata,
    input logic               irq,
    input logic [DROP_W-1:0]  drop_count,
    input logic [1:0]         done,
    input ram_wr_t            ram_wr
);
    assert_reset_clean_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && drop_count == '0 && done == 2'b00));

    assert_one_fill_per_frame_R3: assert property (@(posedge clk) disable iff (rst)
        !($rose(done[0]) && $rose(done[1])));

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(done[0]) || $rose(done[1])) |-> $past(rx_valid && rx_last));

    assert_done_a_cleared_by_sw_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(done[0]) |-> $past(host_wr && host_addr == stat_addr(1'b0)
                                 && !host_wdata[STAT_DONE_BIT]));

    assert_done_b_cleared_by_sw_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(done[1]) |-> $past(host_wr && host_addr == stat_addr(1'b1)
                                 && !host_wdata[STAT_DONE_BIT]));

    assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done != 2'b00));

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

    assert_store_in_window_R9: assert property (@(posedge clk) disable iff (rst)
        ram_wr.en |-> (int'(ram_wr.word) < WORDS));

endmodule

bind dual_rx_buffer drb_chk #(.WORDS(WORDS), .DROP_W(DROP_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_last    (rx_last),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .irq        (irq),
    .drop_count (drop_count),
    .done       (done_q),
    .ram_wr     (ram_wr)
);

// File: tb/dual_rx_buffer_tb_top.sv
module dual_rx_buffer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic [15:0] drop_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic rd_seen = 1'b0;
    int exp_drop = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_rx_buffer dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq),
        .drop_count (drop_count)
    );

    function automatic logic [7:0] byte_of(input int seed, input int k);
        return 8'(seed + k * 13 + (k >> 3));
    endfunction

    function automatic logic [31:0] word_of(input int seed, input int w);
        logic [31:0] v;
        for (int l = 0; l < 4; l++) v[8*l +: 8] = byte_of(seed, 4*w + l);
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = byte_of(seed, k);
            rx_last  = (k == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic host_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_exp(input logic [12:0] a, input logic [31:0] exp,
                            input logic [31:0] mask, input string tag);
        sb_item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        sb_q.push_back(it);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Monitor: the read issued before the last posedge is answered now.
    always @(posedge clk) rd_seen <= host_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected read data actual=%h expected=none", host_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, host_rdata & it.mask, it.exp & it.mask);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'd0);
        check("R1 drop_count after reset", 32'(drop_count), 32'd0);
        read_exp(13'h17FC, 32'h0, 32'hFFFF_FFFF, "R1 status A reset");
        read_exp(13'h1FFC, 32'h0, 32'hFFFF_FFFF, "R1 status B reset");
        read_exp(13'h07F8, 32'h0, 32'hFFFF_FFFF, "R1 global enable reset");

        // R6 R7 enables read back
        host_write(13'h07F8, 32'h8000_0000);
        host_write(13'h17FC, 32'h8);
        host_write(13'h1FFC, 32'h8);
        read_exp(13'h17FC, 32'h8, 32'hFFFF_FFFF, "R6 ie A readback");
        read_exp(13'h07F8, 32'h8000_0000, 32'hFFFF_FFFF, "R7 global enable readback");

        // Frame 1: 10 bytes to A
        send_frame(10, 8'h11);
        check("R6 irq on A done", 32'(irq), 32'd1);
        read_exp(13'h17FC, 32'h9, 32'hFFFF_FFFF, "R4 done A set");
        read_exp(13'h1FFC, 32'h8, 32'hFFFF_FFFF, "R3 B untouched by first frame");
        read_exp(13'h1000, word_of(8'h11, 0), 32'hFFFF_FFFF, "R2 A word0");
        read_exp(13'h1004, word_of(8'h11, 1), 32'hFFFF_FFFF, "R2 A word1");
        read_exp(13'h1008, word_of(8'h11, 2), 32'h0000_FFFF, "R2 A word2 partial");

        // Frame 2: 7 bytes to B
        send_frame(7, 8'h40);
        read_exp(13'h1FFC, 32'h9, 32'hFFFF_FFFF, "R3 second frame to B");
        read_exp(13'h1800, word_of(8'h40, 0), 32'hFFFF_FFFF, "R3 B word0");
        read_exp(13'h1804, word_of(8'h40, 1), 32'h00FF_FFFF, "R2 B word1 partial");

        // Frame 3: both busy -> dropped
        send_frame(5, 8'h77);
        exp_drop++;
        check("R8 drop count after full", 32'(drop_count), 32'(exp_drop));
        read_exp(13'h1000, word_of(8'h11, 0), 32'hFFFF_FFFF, "R8 A unchanged by drop");
        read_exp(13'h1800, word_of(8'h40, 0), 32'hFFFF_FFFF, "R8 B unchanged by drop");

        // R5 writing 1 to done has no effect
        host_write(13'h17FC, 32'h9);
        read_exp(13'h17FC, 32'h9, 32'hFFFF_FFFF, "R5 write one keeps done");
        host_write(13'h17FC, 32'h8);
        read_exp(13'h17FC, 32'h8, 32'hFFFF_FFFF, "R5 write zero clears done A");
        check("R6 irq held by B", 32'(irq), 32'd1);
        host_write(13'h1FFC, 32'h8);
        check("R6 irq low when none done", 32'(irq), 32'd0);

        // Frame 4 to A (drop did not advance the turn); ie A off
        host_write(13'h17FC, 32'h0);
        send_frame(4, 8'h21);
        read_exp(13'h17FC, 32'h1, 32'hFFFF_FFFF, "R8 frame after drop to A");
        check("R6 irq gated by ie", 32'(irq), 32'd0);
        host_write(13'h07F8, 32'h0);
        host_write(13'h17FC, 32'h9);
        check("R7 irq gated by global enable", 32'(irq), 32'd0);
        host_write(13'h07F8, 32'h8000_0000);
        check("R7 irq with global enable", 32'(irq), 32'd1);
        read_exp(13'h1000, word_of(8'h21, 0), 32'hFFFF_FFFF, "R2 A word0 frame4");

        // Frame 5 to B, frame 6 dropped, then turn stays on A
        send_frame(3, 8'h90);
        read_exp(13'h1800, word_of(8'h90, 0), 32'h00FF_FFFF, "R3 frame5 to B");
        send_frame(6, 8'hAB);
        exp_drop++;
        check("R8 second drop", 32'(drop_count), 32'(exp_drop));
        host_write(13'h17FC, 32'h8);
        host_write(13'h1FFC, 32'h8);
        send_frame(8, 8'hC3);
        read_exp(13'h1000, word_of(8'hC3, 0), 32'hFFFF_FFFF, "R8 frame7 to A word0");
        read_exp(13'h1004, word_of(8'hC3, 1), 32'hFFFF_FFFF, "R8 frame7 to A word1");
        read_exp(13'h1FFC, 32'h8, 32'hFFFF_FFFF, "R8 B not done");

        // Frame 8: longer than the buffer, to B
        send_frame(1520, 8'h03);
        read_exp(13'h1FFC, 32'h9, 32'hFFFF_FFFF, "R9 long frame sets done");
        read_exp(13'h1DE8, word_of(8'h03, 378), 32'hFFFF_FFFF, "R9 word 378");
        read_exp(13'h1DEC, word_of(8'h03, 379), 32'h0000_FFFF, "R9 last stored word");
        check("R9 long frame not dropped", 32'(drop_count), 32'(exp_drop));

        // Frame 9: single byte, turn back on A
        host_write(13'h17FC, 32'h8);
        send_frame(1, 8'h5A);
        read_exp(13'h17FC, 32'h9, 32'hFFFF_FFFF, "R3 single byte frame to A");
        read_exp(13'h1000, word_of(8'h5A, 0), 32'h0000_00FF, "R2 single byte lane0");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10 reads unanswered actual=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule